// File: doc/BRIEF.md
# Nine-bit three-wire serial command/parameter transmitter

This block sends bytes to a display controller over a serial link of three wires: an active-low chip select, a serial clock and one data line. Each byte goes out as its own nine-bit frame. The first bit says what the byte is: 0 for a command, 1 for a parameter or pixel byte. The eight payload bits follow, most significant first. Chip select falls at the start of every frame and rises after the last bit. It then stays high for a guard interval before the next frame can start.

The host offers a byte, a data-or-command flag and a valid strobe. The block takes them on a clock edge where both valid and ready are high. Ready then stays low until the guard interval has ended. Each half of a bit cell lasts `HALF_CLKS` system clocks, and the guard interval lasts `GUARD_CLKS` system clocks.

The controller has four named states:

- **ST_IDLE**: ready is high and chip select is high.
- **ST_LOW**: the serial clock is low and the current bit is on the data line.
- **ST_HIGH**: the serial clock is high and the receiver samples.
- **ST_GUARD**: chip select is high again and ready is still low.

The transitions are:

- **accept**: ST_IDLE to ST_LOW when valid is high.
- **rise**: ST_LOW to ST_HIGH when the half period ends.
- **next_bit**: ST_HIGH to ST_LOW when the half period ends and bits remain.
- **end_frame**: ST_HIGH to ST_GUARD when the half period of the ninth bit ends.
- **release**: ST_GUARD to ST_IDLE when the guard time ends.

Top module: `spi9_tx`

## Requirements
- R1: Every frame has exactly nine rising serial-clock edges while chip select is low. The first sampled bit is the flag: 0 when `in_is_data` was 0 (command) and 1 when it was 1 (data).
- R2: The eight payload bits follow the flag in order from bit 7 down to bit 0 of the accepted byte.
- R3: The data line changes only while the serial clock is low. It is stable while the serial clock is high, including on the cycle the clock rises.
- R4: Chip select falls while the serial clock is low, exactly `HALF_CLKS` cycles before the first rising edge. The serial clock is high only while chip select is low, and it is low when chip select rises.
- R5: Every low half and every high half of a bit cell lasts `HALF_CLKS` system clocks.
- R6: Chip select rises when the high half of the ninth bit ends. It then stays high with ready low for exactly `GUARD_CLKS` cycles before ready returns high.
- R7: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. A valid strobe while ready is low is ignored and produces no frame.
- R8: While reset is high, and after it, `cs_n` is high, `scl` is low, `sda` is low, `in_ready` is high and `busy` is low until a byte is accepted.
- R9: `busy` is high exactly while a frame or guard interval is in progress, that is, whenever `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Payload byte |
| in_is_data | input | 1 | 1 for a parameter or data byte, 0 for a command |
| cs_n | output | 1 | Active-low chip select |
| scl | output | 1 | Serial clock, sampled by the receiver on its rising edge |
| sda | output | 1 | Serial data |
| busy | output | 1 | Frame or guard interval in progress |

## Verification
Commands and data bytes are mixed, so that a wrong or inverted flag bit shows up. The payloads are all-zeros, all-ones, alternating patterns and single set bits at either end. These tell a correct most-significant-first order from a reversed order, from an off-by-one shift and from a stuck line. Bytes are sent back to back, so the guard interval and the ready release are measured between real frames. A valid strobe raised during a frame must produce no extra frame.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
    localparam int FRAME_BITS = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GUARD
    } spi9_state_t;
endpackage

// File: rtl/spi9_timer.sv
module spi9_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign done = (cnt == len - 1'b1);
endmodule

// File: rtl/spi9_shifter.sv
module spi9_shifter #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             msb,
    output logic             last
);
    localparam int IW = $clog2(WIDTH);

    logic [WIDTH-1:0] sreg;
    logic [IW-1:0]    idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= din;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign msb  = sreg[WIDTH-1];
    assign last = (idx == IW'(WIDTH - 1));
endmodule

// File: rtl/spi9_tx.sv
module spi9_tx
    import spi9_pkg::*;
#(
    parameter int HALF_CLKS  = 4,
    parameter int GUARD_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    output logic       cs_n,
    output logic       scl,
    output logic       sda,
    output logic       busy
);
    localparam int CNT_MAX = (HALF_CLKS > GUARD_CLKS) ? HALF_CLKS : GUARD_CLKS;
    localparam int TW      = $clog2(CNT_MAX + 1);

    spi9_state_t state, nxt;
    logic          tdone, tclear, last, msb, accept, shift_en;
    logic [TW-1:0] tlen;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid) nxt = ST_LOW;
            ST_LOW:   if (tdone)    nxt = ST_HIGH;
            ST_HIGH:  if (tdone)    nxt = last ? ST_GUARD : ST_LOW;
            ST_GUARD: if (tdone)    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign accept   = (state == ST_IDLE) && in_valid;
    assign shift_en = (state == ST_HIGH) && tdone && !last;
    assign tclear   = (nxt != state) || (state == ST_IDLE);
    assign tlen     = (state == ST_GUARD) ? TW'(GUARD_CLKS) : TW'(HALF_CLKS);

    spi9_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tclear),
        .len   (tlen),
        .done  (tdone)
    );

    spi9_shifter #(.WIDTH(FRAME_BITS)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (shift_en),
        .din   ({in_is_data, in_byte}),
        .msb   (msb),
        .last  (last)
    );

    // outputs
    always_comb begin
        cs_n     = 1'b1;
        scl      = 1'b0;
        sda      = 1'b0;
        in_ready = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
            end
            ST_LOW: begin
                cs_n = 1'b0;
                sda  = msb;
            end
            ST_HIGH: begin
                cs_n = 1'b0;
                scl  = 1'b1;
                sda  = msb;
            end
            ST_GUARD: begin
            end
        endcase
    end
endmodule

// File: rtl/spi9_tx_chk.sv
module spi9_tx_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic scl,
    input logic sda,
    input logic in_ready,
    input logic busy
);
    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        scl |-> $stable(sda)); // R3

    AST_SCL_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        scl |-> !cs_n); // R4

    AST_CS_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !scl); // R4

    AST_GUARD_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> !in_ready); // R6

    AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (cs_n && !scl && !sda && in_ready)); // R8
endmodule

bind spi9_tx spi9_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .scl      (scl),
    .sda      (sda),
    .in_ready (in_ready),
    .busy     (busy)
);

// File: tb/sim_spi9_tx.sv
`timescale 1ns/1ps
module sim_spi9_tx;
    localparam int HALF  = 2;
    localparam int GUARD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_is_data = 1'b0;
    logic in_ready, cs_n, scl, sda, busy;

    int errors = 0;
    int checks = 0;
    int frames = 0;
    int sent = 0;
    bit finished = 1'b0;
    logic [8:0] expq[$];

    always #5 clk = ~clk;

    spi9_tx #(.HALF_CLKS(HALF), .GUARD_CLKS(GUARD)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data),
        .cs_n(cs_n), .scl(scl), .sda(sda), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic d, input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid   = 1'b1;
        in_byte    = b;
        in_is_data = d;
        expq.push_back({d, b});
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    logic prev_cs = 1'b1, prev_scl = 1'b0, prev_sda = 1'b0;
    logic [8:0] shreg;
    int nbits, lowcnt, highcnt, gcnt;
    bit seen_rise, hi_bad, sda_bad, in_guard = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n) begin
                if (prev_cs) begin
                    nbits = 0; lowcnt = 0; highcnt = 0;
                    seen_rise = 0; hi_bad = 0; sda_bad = 0;
                end
                if (scl) begin
                    if (!prev_scl) begin
                        shreg = {shreg[7:0], sda};
                        nbits++;
                        if (!seen_rise) begin
                            seen_rise = 1;
                            chk(lowcnt == HALF, "R4 setup before first rise", lowcnt, HALF);
                        end
                        highcnt = 1;
                    end else begin
                        highcnt++;
                        if (sda != prev_sda) sda_bad = 1;
                    end
                end else begin
                    if (prev_scl && highcnt != HALF) hi_bad = 1;
                    if (!seen_rise) lowcnt++;
                end
            end else begin
                if (!prev_cs) begin
                    if (highcnt != HALF) hi_bad = 1;
                    frames++;
                    chk(!scl, "R4 scl low at cs rise", scl, 0);
                    chk(nbits == 9, "R1 rising edges per frame", nbits, 9);
                    if (expq.size() == 0) begin
                        chk(1'b0, "R7 unexpected frame", shreg, 0);
                    end else begin
                        logic [8:0] e;
                        e = expq.pop_front();
                        chk(shreg[8] == e[8], "R1 flag bit", shreg[8], e[8]);
                        chk(shreg[7:0] == e[7:0], "R2 payload msb first", shreg[7:0], e[7:0]);
                    end
                    chk(!hi_bad, "R5 high half length", highcnt, HALF);
                    chk(!sda_bad, "R3 sda stable while scl high", 1, 0);
                    chk(busy, "R9 busy during guard", busy, 1);
                    in_guard = 1; gcnt = 0;
                end
                if (in_guard) begin
                    if (!in_ready) gcnt++;
                    else begin
                        chk(gcnt == GUARD, "R6 guard length", gcnt, GUARD);
                        chk(!busy, "R9 busy low when ready", busy, 0);
                        in_guard = 0;
                    end
                end
            end
        end
        prev_cs = cs_n; prev_scl = scl; prev_sda = sda;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !scl && !sda, "R8 lines in reset", {cs_n, scl, sda}, 3'b100);
        chk(in_ready && !busy, "R8 handshake in reset", {in_ready, busy}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && in_ready && !busy, "R8 idle after reset", {cs_n, in_ready, busy}, 3'b110);

        send(1'b0, 8'h2A);
        send(1'b1, 8'h00);
        send(1'b1, 8'hFF);
        send(1'b1, 8'hA5);
        send(1'b0, 8'h5A);
        send(1'b1, 8'h80);
        send(1'b1, 8'h01);
        send(1'b0, 8'h11);

        // R7: strobe during a frame must be ignored
        repeat (5) @(negedge clk);
        chk(!in_ready, "R7 ready low during frame", in_ready, 0);
        in_valid = 1'b1; in_byte = 8'h3C; in_is_data = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;

        while (expq.size() != 0 || !in_ready) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(frames == sent, "R7 frame count", frames, sent);
        chk(cs_n && !scl, "R4 idle lines", {cs_n, scl}, 2'b10);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule